// File: doc/BRIEF.md
# Microcoded Add-Multiply Unit

The block computes F = E*(A+B) on three unsigned 8-bit operands. It has a small datapath and a microsequencer that steers it. The datapath holds two operand registers for A and B and a register for E. It also has one adder, one multiplier and a wide accumulator register. A two-way multiplexer loads the accumulator with either the zero-extended sum or the product. The sequencer reads a fixed control store. Each 12-bit word in the store holds 8 control bits and an explicit 4-bit address for the next word.

A client waits until the block is idle, meaning both busy and done are low. It then presents A, B and E and pulses start. The sequence runs four steps:
1. Capture A and B.
2. Add and write the sum into the accumulator.
3. Capture E.
4. Multiply the accumulator by E and write the product back into the accumulator.

A terminal word then raises done for one cycle, and the sequencer returns to its idle word. The result port shows the accumulator at all times.

Top module: `addmul_useq`

## Requirements
- R1: During and after reset, with no start applied, busy and done are both 0. The sequencer rests in its idle word at address 15.
- R2: A start sampled high while idle begins a run. A start sampled high while busy or done is high is ignored: no second run and no extra done pulse follow.
- R3: busy goes high in the cycle after the accepted start and stays high for exactly 4 cycles, which are control-store addresses 0 to 3 in order.
- R4: done is high for exactly one cycle, the first cycle after busy falls. busy is low during that cycle, and the sequencer is idle in the next cycle.
- R5: When done is high, result equals E*(A+B) at full precision in 17 bits. The carry of the sum and the top bit of the product are both kept, so 255,255,255 gives 130050.
- R6: result changes only at the clock edges that end busy cycles. While busy is low, result holds its value.
- R7: A and B are captured at the edge ending the first busy cycle, and E at the edge ending the third. Later changes to the inputs during the run have no effect on the result.
- R8: In the third busy cycle, result shows the zero-extended 9-bit sum A+B.
- R9: If start is held high, runs repeat. Exactly one idle cycle lies between each done cycle and the next busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Run request, accepted only while idle |
| op_a | input | 8 | Operand A |
| op_b | input | 8 | Operand B |
| op_e | input | 8 | Operand E |
| busy | output | 1 | High during the four computation steps |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 17 | Accumulator contents |

## Verification
Random operand triples exercise the general arithmetic. The corner values 0 and 255 expose a lost carry in the 9-bit sum or a truncated top product bit. Some runs change the operand inputs after their capture steps, which shows whether each register samples in its own step rather than at start or at done. Further runs pulse start during busy and hold start high across runs. These separate the idle-only acceptance from a restart, and they pin the single idle cycle between runs.

// File: rtl/addmul_pkg.sv
package addmul_pkg;

  localparam int CTRL_W = 8;
  localparam int NEXT_W = 4;
  localparam int DEPTH  = 1 << NEXT_W;

  typedef struct packed {
    logic wait_go;
    logic done;
    logic busy;
    logic ld_e;
    logic sel_sum;
    logic ld_acc;
    logic ld_b;
    logic ld_a;
  } ctrl_t;

  typedef struct packed {
    ctrl_t             ctrl;
    logic [NEXT_W-1:0] next;
  } uword_t;

  localparam logic [NEXT_W-1:0] ADDR_IDLE = NEXT_W'(DEPTH - 1);
  localparam logic [NEXT_W-1:0] ADDR_FIRST = '0;

  function automatic uword_t ucode(input logic [NEXT_W-1:0] addr);
    uword_t w;
    w = '0;
    w.next = ADDR_IDLE;
    case (addr)
      4'd0: begin w.ctrl.busy = 1'b1; w.ctrl.ld_a = 1'b1; w.ctrl.ld_b = 1'b1; w.next = 4'd1; end
      4'd1: begin w.ctrl.busy = 1'b1; w.ctrl.ld_acc = 1'b1; w.ctrl.sel_sum = 1'b1; w.next = 4'd2; end
      4'd2: begin w.ctrl.busy = 1'b1; w.ctrl.ld_e = 1'b1; w.next = 4'd3; end
      4'd3: begin w.ctrl.busy = 1'b1; w.ctrl.ld_acc = 1'b1; w.next = 4'd4; end
      4'd4: begin w.ctrl.done = 1'b1; w.next = ADDR_IDLE; end
      ADDR_IDLE: begin w.ctrl.wait_go = 1'b1; w.next = ADDR_FIRST; end
      default: w.next = ADDR_IDLE;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/addmul_rstsync.sv
module addmul_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/addmul_ustore.sv
module addmul_ustore
  import addmul_pkg::*;
(
  input  logic [NEXT_W-1:0] addr,
  output uword_t            word
);
  uword_t store [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign store[i] = ucode(NEXT_W'(i));
  end

  assign word = store[addr];
endmodule

// File: rtl/addmul_useq_ctl.sv
module addmul_useq_ctl
  import addmul_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  uword_t            word,
  output logic [NEXT_W-1:0] addr
);
  logic              step_en;
  logic [NEXT_W-1:0] addr_nxt;

  always_comb begin
    step_en  = !word.ctrl.wait_go || start;
    addr_nxt = word.next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= ADDR_IDLE;
    else if (step_en) addr <= addr_nxt;
  end
endmodule

// File: rtl/addmul_dp.sv
module addmul_dp #(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic              ld_e,
  input  logic              ld_acc,
  input  logic              sel_sum,
  input  logic [DW-1:0]     op_a,
  input  logic [DW-1:0]     op_b,
  input  logic [DW-1:0]     op_e,
  output logic [2*DW:0]     result
);
  localparam int SUM_W = DW + 1;
  localparam int RES_W = 2 * DW + 1;

  logic [DW-1:0]    r_a, r_b, r_e;
  logic [RES_W-1:0] r_acc;
  logic [SUM_W-1:0] sum;
  logic [RES_W-1:0] prod;
  logic [RES_W-1:0] acc_nxt;

  always_comb begin
    sum     = SUM_W'(r_a) + SUM_W'(r_b);
    prod    = RES_W'(r_acc[SUM_W-1:0]) * RES_W'(r_e);
    acc_nxt = sel_sum ? RES_W'(sum) : prod;
  end

  always_ff @(posedge clk) begin
    if (ld_a)   r_a   <= op_a;
    if (ld_b)   r_b   <= op_b;
    if (ld_e)   r_e   <= op_e;
    if (ld_acc) r_acc <= acc_nxt;
  end

  assign result = r_acc;
endmodule

// File: rtl/addmul_useq.sv
module addmul_useq
  import addmul_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [DW-1:0] op_e,
  output logic          busy,
  output logic          done,
  output logic [2*DW:0] result
);
  localparam int RES_W = 2 * DW + 1;

  logic              rst_sync_n;
  logic [NEXT_W-1:0] addr;
  uword_t            word;

  addmul_rstsync rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  addmul_ustore store_i (
    .addr (addr),
    .word (word)
  );

  addmul_useq_ctl ctl_i (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (start),
    .word  (word),
    .addr  (addr)
  );

  addmul_dp #(.DW(DW)) dp_i (
    .clk     (clk),
    .ld_a    (word.ctrl.ld_a),
    .ld_b    (word.ctrl.ld_b),
    .ld_e    (word.ctrl.ld_e),
    .ld_acc  (word.ctrl.ld_acc),
    .sel_sum (word.ctrl.sel_sum),
    .op_a    (op_a),
    .op_b    (op_b),
    .op_e    (op_e),
    .result  (result)
  );

  assign busy = word.ctrl.busy;
  assign done = word.ctrl.done;
endmodule

// File: rtl/addmul_chk.sv
module addmul_chk #(
  parameter int RES_W = 17
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [RES_W-1:0] result
);
  logic [2:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_len <= '0;
    else if (busy) run_len <= run_len + 3'd1;
    else           run_len <= '0;
  end

  assert_idle_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !done && start) |=> busy);

  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(start) && !$past(done)));

  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 3'd4));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_done_follows_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(result));
endmodule

bind addmul_useq addmul_chk #(.RES_W(RES_W)) chk_i (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .result (result)
);

// File: tb/addmul_useq_tb_top.sv
`timescale 1ns/1ps
module addmul_useq_tb_top;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [7:0]  op_a, op_b, op_e;
  logic        busy, done;
  logic [16:0] result;

  int checks = 0;
  int errors = 0;
  logic [16:0] exp_q[$];
  int busy_run = 0;
  bit finished = 0;

  addmul_useq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .op_e(op_e),
    .busy(busy), .done(done), .result(result)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [16:0] model(input logic [7:0] av, bv, ev);
    return 17'(ev) * (17'(av) + 17'(bv));
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        check("R3 busy length", 17'(busy_run), 17'd4);
        check("R4 busy low with done", 17'(busy), 17'd0);
        if (exp_q.size() == 0) begin
          check("R2 unexpected done", 17'd1, 17'd0);
        end else begin
          check("R5 result", result, exp_q.pop_front());
        end
      end
      busy_run = busy ? busy_run + 1 : 0;
    end
  end

  task automatic run_op(input logic [7:0] av, bv, ev, input bit wiggle, input bit extra_start);
    @(negedge clk);
    op_a = av; op_b = bv; op_e = ev; start = 1'b1;
    exp_q.push_back(model(av, bv, ev));
    @(negedge clk);                 // busy cycle 1
    start = 1'b0;
    check("R3 busy first cycle", 17'(busy), 17'd1);
    @(negedge clk);                 // busy cycle 2, A/B already captured
    if (wiggle) begin op_a = ~av; op_b = av ^ 8'h5a; end // R7
    if (extra_start) start = 1'b1;  // R2 ignored
    @(negedge clk);                 // busy cycle 3
    start = 1'b0;
    check("R8 sum visible", result, 17'(av) + 17'(bv));
    @(negedge clk);                 // busy cycle 4, E already captured
    if (wiggle) op_e = ~ev;         // R7
    @(negedge clk);                 // done cycle, monitor checks
    check("R4 done cycle", 17'(done), 17'd1);
    @(negedge clk);
    check("R4 idle after done", 17'({busy, done}), 17'd0);
    @(negedge clk);
    check("R2 no restart", 17'(busy), 17'd0);
    check("R6 result held", result, model(av, bv, ev));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0; op_e = '0;
    repeat (3) @(negedge clk);
    check("R1 reset busy", 17'(busy), 17'd0);
    check("R1 reset done", 17'(done), 17'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", 17'({busy, done}), 17'd0);

    run_op(8'd0,   8'd0,   8'd0,   0, 0);
    run_op(8'd255, 8'd255, 8'd255, 0, 0);
    run_op(8'd255, 8'd1,   8'd255, 0, 0);
    run_op(8'd0,   8'd255, 8'd0,   0, 0);
    run_op(8'd7,   8'd9,   8'd255, 1, 0);
    run_op(8'd200, 8'd100, 8'd3,   0, 1);
    run_op(8'd255, 8'd255, 8'd255, 1, 1);
    for (int i = 0; i < 24; i++) begin
      run_op(8'($urandom), 8'($urandom), 8'($urandom), i[0], i[1]);
    end

    // R9: start held high gives back-to-back runs with one idle cycle
    @(negedge clk);
    op_a = 8'd17; op_b = 8'd250; op_e = 8'd201; start = 1'b1;
    exp_q.push_back(model(8'd17, 8'd250, 8'd201));
    exp_q.push_back(model(8'd17, 8'd250, 8'd201));
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    check("R9 first done", 17'(done), 17'd1);
    @(negedge clk);
    check("R9 idle gap", 17'({busy, done}), 17'd0);
    @(negedge clk);
    check("R9 restart", 17'(busy), 17'd1);
    start = 1'b0;
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    check("R9 second done", 17'(done), 17'd1);
    repeat (4) @(negedge clk);
    check("R2 stays idle", 17'(busy), 17'd0);
    check("R5 all results seen", 17'(exp_q.size()), 17'd0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule